// File: doc/BRIEF.md
# SPI Command Stream Interpreter

This block sits between a byte stream carrying packed SPI commands and a byte-level SPI master engine. Each command byte names one of four actions in its top two bits: select or release a chip, read, write, or write while reading. A select may also carry a new sampling edge and a 16-bit clock setting. The interpreter tracks which chip is selected and at what clock and edge, and holds those values on its control outputs for the engine. It then runs the byte transfers, one at a time, through a request/completion handshake.

Transfer lengths are powers of two, and the command carries only the exponent. Write payload bytes come from the same input stream and are handed to the engine unchanged. Bytes captured by reads leave on a separate byte-wide valid/ready stream, in the order they were transferred. A full output register holds back the next capturing transfer, so a slow consumer stalls the engine between bytes. A command whose exponent is larger than the configured maximum is dropped and reported by a one-cycle error pulse.

Top module: `spi_cmd_parser`

## Requirements
- R1: After reset `cs_active` is 0, `cs_sel` is 0, `spi_edge` equals RESET_EDGE, `spi_clk_div` equals RESET_CLK, and `rd_valid`, `eng_valid` and `len_err` are 0.
- R2: Bits [7:6] of a command byte select the action: 0 = chip select, 1 = read, 2 = write, 3 = write-and-read. For the last three, bits [5:0] hold an exponent E.
- R3: A chip-select byte with bit 5 set and bit 3 clear sets `cs_active` to 1 and `cs_sel` to bits [1:0] in the cycle after the byte is accepted. The clock and edge stay as they were, and no operand bytes follow.
- R4: A chip-select byte with bits 5 and 3 both set is followed by two operand bytes, high byte first, which form the new `spi_clk_div`. Bit 2 gives the new `spi_edge` (1 = rising). `cs_active`, `cs_sel`, `spi_edge` and `spi_clk_div` all change together, in the cycle after the low operand byte is accepted.
- R5: A chip-select byte with bit 5 clear drives `cs_active` to 0 in the next cycle, whatever chip it names. `cs_sel` keeps its value, and no operand bytes follow.
- R6: A read, write or write-and-read command with E <= MAX_EXP performs exactly 2^E engine transfers, and then no more.
- R7: A write command takes exactly 2^E further input bytes. Each one appears on `eng_tx` in the cycle its transfer is requested, and no byte is produced on the output stream.
- R8: A read command takes no operand bytes. Each of its transfers sends FILL_BYTE, and each `eng_rx` byte appears on `rd_data` in transfer order.
- R9: A write-and-read command takes 2^E input bytes as for a write, and also emits every captured byte in order, as for a read.
- R10: While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` and `rd_data` stay unchanged. No capturing transfer is requested while `rd_valid` is 1.
- R11: From an accepted engine request until the matching `eng_done`, `cmd_ready` and `eng_valid` are 0 and the chip-select outputs do not change. The next command byte is taken only after the last transfer of the previous command has completed.
- R12: A read, write or write-and-read byte with E > MAX_EXP raises `len_err` for exactly the following cycle and starts no transfer. The next input byte is decoded as a new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command stream byte valid |
| cmd_data | input | 8 | Command stream byte |
| cmd_ready | output | 1 | Command stream byte accepted |
| rd_valid | output | 1 | Captured byte valid |
| rd_data | output | 8 | Captured byte |
| rd_ready | input | 1 | Consumer takes captured byte |
| eng_valid | output | 1 | Request one engine byte transfer |
| eng_tx | output | 8 | Byte to shift out |
| eng_ready | input | 1 | Engine accepts the request |
| eng_done | input | 1 | Engine finished the accepted transfer |
| eng_rx | input | 8 | Byte shifted in, valid with eng_done |
| cs_active | output | 1 | A chip select is asserted |
| cs_sel | output | 2 | Chip number to select |
| spi_edge | output | 1 | Sampling edge, 1 = rising |
| spi_clk_div | output | 16 | Clock setting in units of 2048 Hz |
| len_err | output | 1 | One-cycle pulse: oversize length dropped |

## Verification
On every cycle, the checker enforces these behaviours: the output byte holds while it is stalled, no capturing request is made against a full output register, input and requests stay quiet while a transfer is in flight, captured bytes appear only after a completion, and an error pulse never coincides with transfer activity. Only the bench scenarios can show the remaining behaviours. These are operand framing for clock updates, the exact count of 2^E transfers, the order and content of forwarded and captured bytes under engine and consumer stalls, and the re-decoding of the byte that follows a dropped command.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

   typedef enum logic [1:0] {
      OP_CS = 2'd0,
      OP_RD = 2'd1,
      OP_WR = 2'd2,
      OP_RW = 2'd3
   } op_e;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_CLKH,
      ST_CLKL,
      ST_XFER,
      ST_WAIT
   } st_e;

   typedef struct packed {
      op_e        op;
      logic [1:0] chip;
      logic       do_assert;
      logic       has_cfg;
      logic       rise;
      logic [5:0] expo;
   } cmd_t;

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
   import spi_cmd_pkg::*;
#(
   parameter int MAX_EXP = 12
) (
   input  logic [7:0] byte_i,
   output cmd_t       cmd_o,
   output logic       len_ok_o
);
   localparam logic [5:0] MAX_E6 = 6'(MAX_EXP);

   always_comb begin
      cmd_o.op        = op_e'(byte_i[7:6]);
      cmd_o.chip      = byte_i[1:0];
      cmd_o.do_assert = byte_i[5];
      cmd_o.has_cfg   = byte_i[3];
      cmd_o.rise      = byte_i[2];
      cmd_o.expo      = byte_i[5:0];
   end

   generate
      if (MAX_EXP >= 63) begin : g_full
         assign len_ok_o = 1'b1;
      end else begin : g_limited
         assign len_ok_o = (byte_i[5:0] <= MAX_E6);
      end
   endgenerate
endmodule

// File: rtl/spi_cmd_cfg.sv
module spi_cmd_cfg #(
   parameter int          CLK_W      = 16,
   parameter logic [15:0] RESET_CLK  = 16'd1,
   parameter logic        RESET_EDGE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_i,
   input  logic             clr_i,
   input  logic             upd_i,
   input  logic [1:0]       chip_i,
   input  logic             rise_i,
   input  logic [CLK_W-1:0] div_i,
   output logic             active_o,
   output logic [1:0]       sel_o,
   output logic             rise_o,
   output logic [CLK_W-1:0] div_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_o <= 1'b0;
         sel_o    <= 2'd0;
         rise_o   <= RESET_EDGE;
         div_o    <= CLK_W'(RESET_CLK);
      end else begin
         if (set_i) begin
            active_o <= 1'b1;
            sel_o    <= chip_i;
         end else if (clr_i) begin
            active_o <= 1'b0;
         end
         if (upd_i) begin
            rise_o <= rise_i;
            div_o  <= div_i;
         end
      end
   end
endmodule

// File: rtl/spi_cmd_len.sv
module spi_cmd_len #(
   parameter int MAX_EXP = 12
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load_i,
   input  logic [5:0] expo_i,
   input  logic       dec_i,
   output logic       last_o
);
   localparam int CNT_W = MAX_EXP + 1;

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= CNT_W'(1) << expo_i;
      end else if (dec_i) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/spi_cmd_parser.sv
module spi_cmd_parser
   import spi_cmd_pkg::*;
#(
   parameter int          MAX_EXP    = 12,
   parameter logic [7:0]  FILL_BYTE  = 8'h00,
   parameter logic [15:0] RESET_CLK  = 16'd1,
   parameter logic        RESET_EDGE = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [7:0]  cmd_data,
   output logic        cmd_ready,
   output logic        rd_valid,
   output logic [7:0]  rd_data,
   input  logic        rd_ready,
   output logic        eng_valid,
   output logic [7:0]  eng_tx,
   input  logic        eng_ready,
   input  logic        eng_done,
   input  logic [7:0]  eng_rx,
   output logic        cs_active,
   output logic [1:0]  cs_sel,
   output logic        spi_edge,
   output logic [15:0] spi_clk_div,
   output logic        len_err
);
   localparam int CLK_W = 16;

   generate
      if (MAX_EXP < 0 || MAX_EXP > 63) begin : g_bad_exp
         $error("spi_cmd_parser: MAX_EXP must lie in 0..63");
      end
   endgenerate

   st_e        st_q;
   op_e        kind_q;
   logic [7:0] clk_hi_q;
   logic [1:0] pend_chip_q;
   logic       pend_rise_q;
   logic       rd_valid_q;
   logic [7:0] rd_data_q;
   logic       len_err_q;

   cmd_t       dcmd;
   logic       len_ok;
   logic       take;
   logic       cap_w;
   logic       src_in;
   logic       slot_free;
   logic       issue;
   logic       len_last;
   logic       cfg_set;
   logic       cfg_clr;
   logic       cfg_upd;
   logic [1:0] cfg_chip;

   spi_cmd_decode #(.MAX_EXP(MAX_EXP)) u_dec (
      .byte_i   (cmd_data),
      .cmd_o    (dcmd),
      .len_ok_o (len_ok)
   );

   assign cap_w     = (kind_q != OP_WR);
   assign src_in    = (kind_q != OP_RD);
   assign slot_free = !rd_valid_q || !cap_w;

   always_comb begin
      eng_valid = 1'b0;
      cmd_ready = 1'b0;
      unique case (st_q)
         ST_CMD, ST_CLKH, ST_CLKL: cmd_ready = 1'b1;
         ST_XFER: begin
            eng_valid = slot_free && (src_in ? cmd_valid : 1'b1);
            cmd_ready = src_in && slot_free && eng_ready;
         end
         default: ;
      endcase
   end

   assign eng_tx = src_in ? cmd_data : FILL_BYTE;
   assign take   = cmd_valid && cmd_ready;
   assign issue  = eng_valid && eng_ready;

   assign cfg_set  = ((st_q == ST_CMD) && take && (dcmd.op == OP_CS) &&
                      dcmd.do_assert && !dcmd.has_cfg) ||
                     ((st_q == ST_CLKL) && take);
   assign cfg_clr  = (st_q == ST_CMD) && take && (dcmd.op == OP_CS) && !dcmd.do_assert;
   assign cfg_upd  = (st_q == ST_CLKL) && take;
   assign cfg_chip = (st_q == ST_CLKL) ? pend_chip_q : dcmd.chip;

   spi_cmd_cfg #(
      .CLK_W      (CLK_W),
      .RESET_CLK  (RESET_CLK),
      .RESET_EDGE (RESET_EDGE)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (cfg_set),
      .clr_i    (cfg_clr),
      .upd_i    (cfg_upd),
      .chip_i   (cfg_chip),
      .rise_i   (pend_rise_q),
      .div_i    ({clk_hi_q, cmd_data}),
      .active_o (cs_active),
      .sel_o    (cs_sel),
      .rise_o   (spi_edge),
      .div_o    (spi_clk_div)
   );

   logic len_load;
   logic len_dec;
   assign len_load = (st_q == ST_CMD) && take && (dcmd.op != OP_CS) && len_ok;
   assign len_dec  = (st_q == ST_WAIT) && eng_done;

   spi_cmd_len #(.MAX_EXP(MAX_EXP)) u_len (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (len_load),
      .expo_i (dcmd.expo),
      .dec_i  (len_dec),
      .last_o (len_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q        <= ST_CMD;
         kind_q      <= OP_CS;
         clk_hi_q    <= 8'd0;
         pend_chip_q <= 2'd0;
         pend_rise_q <= 1'b0;
         len_err_q   <= 1'b0;
      end else begin
         len_err_q <= 1'b0;
         unique case (st_q)
            ST_CMD: if (take) begin
               if (dcmd.op == OP_CS) begin
                  if (dcmd.do_assert && dcmd.has_cfg) begin
                     pend_chip_q <= dcmd.chip;
                     pend_rise_q <= dcmd.rise;
                     st_q        <= ST_CLKH;
                  end
               end else if (len_ok) begin
                  kind_q <= dcmd.op;
                  st_q   <= ST_XFER;
               end else begin
                  len_err_q <= 1'b1;
               end
            end
            ST_CLKH: if (take) begin
               clk_hi_q <= cmd_data;
               st_q     <= ST_CLKL;
            end
            ST_CLKL: if (take) st_q <= ST_CMD;
            ST_XFER: if (issue) st_q <= ST_WAIT;
            ST_WAIT: if (eng_done) st_q <= len_last ? ST_CMD : ST_XFER;
            default: st_q <= ST_CMD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_q <= 1'b0;
         rd_data_q  <= 8'd0;
      end else if (len_dec && cap_w) begin
         rd_valid_q <= 1'b1;
         rd_data_q  <= eng_rx;
      end else if (rd_valid_q && rd_ready) begin
         rd_valid_q <= 1'b0;
      end
   end

   assign rd_valid = rd_valid_q;
   assign rd_data  = rd_data_q;
   assign len_err  = len_err_q;
endmodule

// File: rtl/spi_cmd_parser_chk.sv
module spi_cmd_parser_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_ready,
   input logic       rd_valid,
   input logic [7:0] rd_data,
   input logic       rd_ready,
   input logic       eng_valid,
   input logic       eng_ready,
   input logic       eng_done,
   input logic       cs_active,
   input logic [1:0] cs_sel,
   input logic       len_err,
   input logic       cap_i
);
   logic busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     busy_q <= 1'b0;
      else if (eng_valid && eng_ready) busy_q <= 1'b1;
      else if (eng_done)               busy_q <= 1'b0;
   end

   p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

   p_no_cap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_valid && cap_i |-> !rd_valid);

   p_busy_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> !cmd_ready && !eng_valid);

   p_cs_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> $stable(cs_active) && $stable(cs_sel));

   p_rd_from_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(eng_done));

   p_err_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      len_err |-> !eng_valid && !busy_q);
endmodule

bind spi_cmd_parser spi_cmd_parser_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_ready (cmd_ready),
   .rd_valid  (rd_valid),
   .rd_data   (rd_data),
   .rd_ready  (rd_ready),
   .eng_valid (eng_valid),
   .eng_ready (eng_ready),
   .eng_done  (eng_done),
   .cs_active (cs_active),
   .cs_sel    (cs_sel),
   .len_err   (len_err),
   .cap_i     (cap_w)
);

// File: tb/tb_spi_cmd_parser.sv
module tb_spi_cmd_parser;
   localparam int         MAXE = 5;
   localparam logic [7:0] FILL = 8'h5A;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [7:0]  cmd_data = 8'd0;
   logic        cmd_ready;
   logic        rd_valid;
   logic [7:0]  rd_data;
   logic        rd_ready = 1'b1;
   logic        eng_valid;
   logic [7:0]  eng_tx;
   logic        eng_ready = 1'b0;
   logic        eng_done = 1'b0;
   logic [7:0]  eng_rx = 8'd0;
   logic        cs_active;
   logic [1:0]  cs_sel;
   logic        spi_edge;
   logic [15:0] spi_clk_div;
   logic        len_err;

   always #2 clk = ~clk;

   spi_cmd_parser #(
      .MAX_EXP(MAXE), .FILL_BYTE(FILL), .RESET_CLK(16'd100), .RESET_EDGE(1'b1)
   ) dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
      .rd_ready(rd_ready), .eng_valid(eng_valid), .eng_tx(eng_tx),
      .eng_ready(eng_ready), .eng_done(eng_done), .eng_rx(eng_rx),
      .cs_active(cs_active), .cs_sel(cs_sel), .spi_edge(spi_edge),
      .spi_clk_div(spi_clk_div), .len_err(len_err)
   );

   int nchk = 0;
   int nerr = 0;
   bit started = 0;

   // reference model state
   bit         m_act = 0;
   bit [1:0]   m_sel = 0;
   bit         m_edge = 1;
   bit [15:0]  m_clk = 16'd100;
   bit         m_err = 0;
   int         m_ops = 0;
   bit [7:0]   m_hi = 0;
   bit [1:0]   m_psel = 0;
   bit         m_pedge = 0;
   int         m_wr_left = 0;
   bit         m_wr_cap = 0;
   bit [7:0]   exp_tx_q[$];
   bit         exp_cap_q[$];
   bit [7:0]   exp_out_q[$];
   bit         cur_cap = 0;

   // engine and consumer models
   bit  eng_acc = 0;
   bit  eng_busy = 0;
   int  eng_dly = 0;
   int  rx_seq = 0;
   int  cyc = 0;
   bit  bp = 0;
   bit  eng_slow = 0;
   bit  prev_stall = 0;
   bit [7:0] prev_data = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, expv);
      end
   endtask

   function automatic void parse(input bit [7:0] b);
      if (m_wr_left > 0) begin
         exp_tx_q.push_back(b);
         exp_cap_q.push_back(m_wr_cap);
         m_wr_left--;
      end else if (m_ops == 2) begin
         m_hi = b; m_ops = 1;
      end else if (m_ops == 1) begin
         m_act = 1; m_sel = m_psel; m_edge = m_pedge; m_clk = {m_hi, b}; m_ops = 0;
      end else begin
         case (b[7:6])
            2'd0: begin
               if (b[5]) begin
                  if (b[3]) begin m_psel = b[1:0]; m_pedge = b[2]; m_ops = 2; end
                  else begin m_act = 1; m_sel = b[1:0]; end
               end else m_act = 0;
            end
            2'd1: begin
               if (int'(b[5:0]) > MAXE) m_err = 1;
               else for (int i = 0; i < (1 << b[5:0]); i++) begin
                  exp_tx_q.push_back(FILL);
                  exp_cap_q.push_back(1'b1);
               end
            end
            default: begin
               if (int'(b[5:0]) > MAXE) m_err = 1;
               else begin m_wr_left = 1 << b[5:0]; m_wr_cap = (b[7:6] == 2'd3); end
            end
         endcase
      end
   endfunction

   // per-cycle comparison against the model, away from the active edge
   always @(negedge clk) begin
      if (rst_n && started) begin
         chk(cs_active == m_act && cs_sel == m_sel && spi_edge == m_edge && spi_clk_div == m_clk,
             "R3/R4/R5 config", {cs_active, cs_sel, spi_edge, spi_clk_div},
             {m_act, m_sel, m_edge, m_clk});
         chk(len_err == m_err, "R12 len_err", len_err, m_err);
         m_err = 0;
         if (prev_stall)
            chk(rd_valid && rd_data == prev_data, "R10 hold", {rd_valid, rd_data}, {1'b1, prev_data});
         prev_stall = rd_valid && !rd_ready;
         prev_data  = rd_data;
         if (eng_busy)
            chk(!cmd_ready && !eng_valid, "R11 busy", {cmd_ready, eng_valid}, 0);
         if (cmd_valid && cmd_ready) parse(cmd_data);
         if (eng_valid && eng_ready) begin
            if (exp_tx_q.size() == 0) begin
               chk(0, "R6 extra transfer", eng_tx, 0);
            end else begin
               bit [7:0] e;
               e = exp_tx_q.pop_front();
               cur_cap = exp_cap_q.pop_front();
               chk(eng_tx == e, "R2/R7/R8/R9 tx", eng_tx, e);
               if (cur_cap) chk(!rd_valid, "R10 no issue when full", rd_valid, 0);
            end
            eng_acc = 1;
         end
         if (eng_done && cur_cap) exp_out_q.push_back(eng_rx);
         if (rd_valid && rd_ready) begin
            if (exp_out_q.size() == 0) chk(0, "R7 unexpected output", rd_data, 0);
            else begin
               bit [7:0] e;
               e = exp_out_q.pop_front();
               chk(rd_data == e, "R8/R9 rd_data", rd_data, e);
            end
         end
      end
   end

   // engine model
   initial begin
      forever begin
         @(posedge clk); #1;
         cyc++;
         eng_done = 0;
         if (eng_acc) begin
            eng_acc = 0; eng_busy = 1; eng_dly = rx_seq % 3;
         end else if (eng_busy) begin
            if (eng_dly == 0) begin
               eng_done = 1; eng_rx = 8'(rx_seq * 7 + 3); rx_seq++; eng_busy = 0;
            end else eng_dly--;
         end
         eng_ready = !eng_busy && (eng_slow ? cyc[0] : 1'b1);
         rd_ready  = bp ? (cyc % 4 == 0) : 1'b1;
      end
   end

   task automatic send(input bit [7:0] b);
      cmd_valid = 1; cmd_data = b;
      forever begin
         @(negedge clk);
         if (cmd_ready) break;
      end
      @(posedge clk); #1;
      cmd_valid = 0; cmd_data = 8'd0;
   endtask

   task automatic drain(input string req);
      for (int i = 0; i < 2000; i++) begin
         @(negedge clk);
         if (exp_tx_q.size() == 0 && exp_out_q.size() == 0 && m_wr_left == 0 &&
             !eng_busy && !eng_acc && !rd_valid) break;
      end
      chk(exp_tx_q.size() == 0 && exp_out_q.size() == 0, req,
          exp_tx_q.size() + exp_out_q.size(), 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog R11: actual hung expected done");
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(!cs_active && cs_sel == 0 && spi_edge && spi_clk_div == 16'd100 &&
          !rd_valid && !eng_valid && !len_err, "R1 reset",
          {cs_active, cs_sel, spi_edge, spi_clk_div, rd_valid, eng_valid, len_err},
          {1'b0, 2'd0, 1'b1, 16'd100, 3'd0});
      started = 1;
      @(posedge clk); #1;

      send(8'h22);                                   // R3 assert chip 2, keep clock
      send(8'h29); send(8'h12); send(8'h34);         // R4 chip 1, falling, 0x1234
      send(8'h82); for (int i = 0; i < 4; i++) send(8'(8'h10 + i));  // R7 write 4
      drain("R6 write count");
      send(8'h43);                                   // R8 read 8
      drain("R6 read count");
      send(8'hC1); send(8'hAB); send(8'hCD);         // R9 write-and-read 2
      drain("R6 rw count");
      send(8'h03);                                   // R5 release, names chip 3
      send(8'h2C); send(8'hFF); send(8'h01);         // R4 chip 0, rising
      send(8'h46);                                   // R12 read E=6 dropped
      send(8'h21);                                   // R12 next byte is a command
      send(8'hBF);                                   // R12 write E=63 dropped
      send(8'h80); send(8'h77);                      // R7 E=0 single byte
      drain("R6 single");
      bp = 1; eng_slow = 1;
      send(8'h45);                                   // R10 read 32 under backpressure
      drain("R6 max length");
      send(8'hC2); for (int i = 0; i < 4; i++) send(8'(8'hE0 + i));  // R9/R10
      drain("R6 rw stalled");
      send(8'h05);                                   // R5 release
      bp = 0; eng_slow = 0;
      send(8'h42);                                   // R11 back-to-back commands
      send(8'h81); send(8'h99); send(8'h9A);
      drain("R11 sequence");
      repeat (4) @(negedge clk);
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   end
endmodule